// File: doc/BRIEF.md
# Bucketed Sample Rate Generator

This block sits at the front of a fast digitizer capture path and runs entirely from a 24 MHz reference clock. It never gates that clock. It turns the clock into a set of single-cycle enables. A sample strobe fires at most every second reference cycle, so the fastest sample rate is 12 MHz. Consecutive samples are grouped into buckets of a programmable length, and each bucket has a first-sample flag and a last-sample flag. A downstream peak or pit detector uses the first-sample flag to force-load a fresh value, so the first sample of every bucket is always kept.

Once per bucket the block advances a free-running circular write address into the capture memory. That address wraps from its top value back to zero. After a trigger, a separate enable drives a post-trigger bucket counter. When the counter reaches the programmed count, capture stops, the address freezes on the last bucket and a sticky done flag is raised. Software loads the bucket length and the post-trigger count, then pulses arm. Both settings are captured at that moment. The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `bucket_rate_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every strobe is low, done is low and wr_addr is 0. Until the first arm, the block stays idle with no strobes.
- R2: An arm pulse captures spb_cfg and post_cfg. It clears done, wr_addr and the bucket and post-trigger counters, and starts capture. The first sample strobe appears in the second cycle after the cycle in which arm was high.
- R3: smp_stb is never high in two consecutive cycles. With spb_cfg = 0, it is high in every second cycle while capture runs.
- R4: The spb_cfg field holds N-1, so 0 means 1 sample per bucket and 255 means 256. Every bucket holds exactly spb_cfg+1 strobes. bkt_first is high on the first strobe of a bucket, bkt_end is high on the last, and both are high only together with smp_stb.
- R5: addr_en is high exactly when bkt_end is high. wr_addr increases by one in the following cycle, wraps from 32767 to 0, and holds in every other case apart from arm.
- R6: ptc_en is high only on bucket ends that occur after an accepted trigger. A bucket end in the same cycle as the trigger does not count.
- R7: trig is accepted only while armed and not yet triggered. It is ignored while idle, when it arrives in the same cycle as arm, after a trigger has already been accepted, and after done.
- R8: After post_cfg ptc_en pulses (a post_cfg of 0 counts as 1), done rises in the next cycle. All strobes then stop and wr_addr holds. done stays high until the next arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| spb_cfg | input | 8 | Samples per bucket minus one |
| post_cfg | input | 16 | Buckets to capture after the trigger |
| arm | input | 1 | Start a new capture (single-cycle pulse) |
| trig | input | 1 | Trigger event |
| smp_stb | output | 1 | ADC sample enable |
| bkt_first | output | 1 | First sample of a bucket |
| bkt_end | output | 1 | Last sample of a bucket |
| addr_en | output | 1 | Write-address counter enable |
| ptc_en | output | 1 | Post-trigger counter enable |
| wr_addr | output | 15 | Circular capture-memory write address |
| done | output | 1 | Capture finished (sticky until arm) |

## Verification
The bound assertions check, on every cycle, the properties that relate strobes to one another and to the address:
- no back-to-back samples;
- both bucket flags appear only with a sample;
- each address enable gives a one-step advance modulo 32768, and the address holds otherwise;
- ptc_en appears only on a bucket end;
- the block is quiet and done stays set after done;
- arm clears done.

Some behaviour only the bench scenarios can show: that buckets hold exactly spb_cfg+1 samples, when the first strobe appears after arm, which triggers are ignored, how many post-trigger buckets pass before done (including the zero case), and the wrap at 32767. The bench shows these by comparing every output against a behavioural model on each cycle and by directed counts.

// File: rtl/bucket_rate_pkg.sv
package bucket_rate_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_t;
endpackage

// File: rtl/bucket_rate_div.sv
// Divide-by-two sample pacing plus in-bucket sample counter.
module bucket_rate_div #(
  parameter int SPB_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [SPB_W-1:0] spb,
  output logic             smp,
  output logic             first,
  output logic             last
);
  logic             phase_q;
  logic [SPB_W-1:0] cnt_q;

  assign smp   = run & phase_q;
  assign first = smp & (cnt_q == '0);
  assign last  = smp & (cnt_q == spb);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (run) begin
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bucket_capture_ctl.sv
// Arm / trigger / post-trigger bucket count sequencing.
module bucket_capture_ctl
  import bucket_rate_pkg::*;
#(
  parameter int PTC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             trig,
  input  logic             bkt_end,
  input  logic [PTC_W-1:0] post_cfg,
  output cap_state_t       state,
  output logic             ptc_en
);
  logic [PTC_W-1:0] pcnt_q;
  logic [PTC_W-1:0] post_q;
  logic [PTC_W:0]   pcnt_nxt;

  assign ptc_en   = (state == CAP_POST) & bkt_end;
  assign pcnt_nxt = {1'b0, pcnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CAP_IDLE;
      pcnt_q <= '0;
      post_q <= '0;
    end else if (arm) begin
      state  <= CAP_ARMED;
      pcnt_q <= '0;
      post_q <= post_cfg;
    end else begin
      case (state)
        CAP_ARMED: if (trig) state <= CAP_POST;
        CAP_POST: if (ptc_en) begin
          pcnt_q <= pcnt_nxt[PTC_W-1:0];
          if (pcnt_nxt >= {1'b0, post_q}) state <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bucket_wrap_ctr.sv
// Free-running wrap-around counter with clear and enable.
module bucket_wrap_ctr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= q + 1'b1;
  end
endmodule

// File: rtl/bucket_rate_gen.sv
module bucket_rate_gen
  import bucket_rate_pkg::*;
#(
  parameter int SPB_W  = 8,
  parameter int ADDR_W = 15,
  parameter int PTC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPB_W-1:0]  spb_cfg,
  input  logic [PTC_W-1:0]  post_cfg,
  input  logic              arm,
  input  logic              trig,
  output logic              smp_stb,
  output logic              bkt_first,
  output logic              bkt_end,
  output logic              addr_en,
  output logic              ptc_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);
  cap_state_t       state;
  logic [SPB_W-1:0] spb_q;
  logic             running;

  assign running = (state == CAP_ARMED) | (state == CAP_POST);
  assign done    = (state == CAP_DONE);
  assign addr_en = bkt_end;

  always_ff @(posedge clk) begin
    if (rst)      spb_q <= '0;
    else if (arm) spb_q <= spb_cfg;
  end

  bucket_rate_div #(.SPB_W(SPB_W)) i_div (
    .clk(clk), .rst(rst), .restart(arm), .run(running), .spb(spb_q),
    .smp(smp_stb), .first(bkt_first), .last(bkt_end)
  );

  bucket_capture_ctl #(.PTC_W(PTC_W)) i_ctl (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .bkt_end(bkt_end),
    .post_cfg(post_cfg), .state(state), .ptc_en(ptc_en)
  );

  bucket_wrap_ctr #(.W(ADDR_W)) i_addr (
    .clk(clk), .rst(rst), .clr(arm), .en(addr_en), .q(wr_addr)
  );
endmodule

// File: rtl/bucket_rate_gen_chk.sv
module bucket_rate_gen_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic              smp_stb,
  input logic              bkt_first,
  input logic              bkt_end,
  input logic              addr_en,
  input logic              ptc_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) smp_stb |=> !smp_stb); // R3
  AST_FIRST_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst) bkt_first |-> smp_stb); // R4
  AST_END_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst) bkt_end |-> smp_stb); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) (addr_en && !arm) |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (!addr_en && !arm) |=> $stable(wr_addr)); // R5
  AST_PTC_ON_END: assert property (@(posedge clk) disable iff (rst) ptc_en |-> addr_en); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> !(smp_stb || addr_en || ptc_en)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) (done && !arm) |=> done); // R8
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst) arm |=> (!done && wr_addr == '0)); // R2
endmodule

bind bucket_rate_gen bucket_rate_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .arm(arm), .smp_stb(smp_stb), .bkt_first(bkt_first),
  .bkt_end(bkt_end), .addr_en(addr_en), .ptc_en(ptc_en), .wr_addr(wr_addr), .done(done)
);

// File: tb/test_bucket_rate_gen.sv
module test_bucket_rate_gen;
  localparam int CLK_PERIOD = 42;
  localparam int ASPAN = 32768;
  localparam int WDOG = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  spb_cfg = '0;
  logic [15:0] post_cfg = '0;
  logic        arm = 1'b0;
  logic        trig = 1'b0;
  logic        smp_stb, bkt_first, bkt_end, addr_en, ptc_en, done;
  logic [14:0] wr_addr;

  int tests = 0, fails = 0, cyc = 0;
  int m_st, m_ph, m_sc, m_spb, m_post, m_pc, m_addr;
  int smp_in, ptc_seen, exp_spb;
  bit finished = 0;

  bucket_rate_gen i_bucket_rate_gen (
    .clk(clk), .rst(rst), .spb_cfg(spb_cfg), .post_cfg(post_cfg), .arm(arm),
    .trig(trig), .smp_stb(smp_stb), .bkt_first(bkt_first), .bkt_end(bkt_end),
    .addr_en(addr_en), .ptc_en(ptc_en), .wr_addr(wr_addr), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  always @(posedge clk) begin
    bit run, samp, last_s;
    cyc++;
    if (rst) begin
      m_st = 0; m_ph = 0; m_sc = 0; m_spb = 0; m_post = 0; m_pc = 0; m_addr = 0;
    end else begin
      run    = (m_st == 1 || m_st == 2);
      samp   = run && m_ph == 1;
      last_s = samp && m_sc == m_spb;
      if (arm) begin
        m_st = 1; m_ph = 0; m_sc = 0; m_pc = 0; m_addr = 0;
        m_spb = spb_cfg; m_post = post_cfg;
      end else begin
        if (samp) m_sc = last_s ? 0 : m_sc + 1;
        if (run) m_ph = 1 - m_ph;
        if (last_s) m_addr = (m_addr + 1) % ASPAN;
        if (m_st == 1) begin
          if (trig) m_st = 2;
        end else if (m_st == 2 && last_s) begin
          m_pc++;
          if (m_pc >= ((m_post == 0) ? 1 : m_post)) m_st = 3;
        end
      end
    end
  end

  // Per-cycle comparison and bucket monitor, away from the active edge.
  always @(negedge clk) begin
    bit run, samp, last_s;
    if (!rst && !finished) begin
      run    = (m_st == 1 || m_st == 2);
      samp   = run && m_ph == 1;
      last_s = samp && m_sc == m_spb;
      chk(smp_stb == samp, "R3 smp_stb", smp_stb, samp);
      chk(bkt_first == (samp && m_sc == 0) && bkt_end == last_s, "R4 bucket flags",
          {bkt_first, bkt_end}, {samp && m_sc == 0, last_s});
      chk(wr_addr == m_addr && addr_en == last_s, "R5 address", wr_addr, m_addr);
      chk(ptc_en == (last_s && m_st == 2), "R6 ptc_en", ptc_en, last_s && m_st == 2);
      chk(done == (m_st == 3), "R8 done", done, m_st == 3);
      if (smp_stb) smp_in++;
      if (bkt_end) begin
        chk(smp_in == exp_spb + 1, "R4 samples per bucket", smp_in, exp_spb + 1);
        smp_in = 0;
      end
      if (ptc_en) ptc_seen++;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_arm(input int spb, input int post, input bit with_trig = 0);
    @(negedge clk);
    spb_cfg = spb[7:0]; post_cfg = post[15:0]; arm = 1; trig = with_trig;
    smp_in = 0; ptc_seen = 0; exp_spb = spb;
    @(negedge clk);
    arm = 0; trig = 0;
  endtask

  task automatic pulse_trig();
    trig = 1; tick(); trig = 0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) tick();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a;
    tick(3);
    chk(!smp_stb && !addr_en && !ptc_en && !done && wr_addr == 0, "R1 reset state", wr_addr, 0);
    rst = 0;
    tick();
    chk(!smp_stb && !done && wr_addr == 0, "R1 after release", smp_stb, 0);
    // Trigger while idle is ignored.
    pulse_trig(); tick(10);
    chk(!done && wr_addr == 0 && !smp_stb, "R7 idle trigger", done, 0);

    // Fastest rate, three post buckets.
    do_arm(0, 3);
    chk(smp_stb == 0, "R2 no strobe first cycle", smp_stb, 0);
    tick();
    chk(smp_stb == 1, "R2 first strobe second cycle", smp_stb, 1);
    tick(9); pulse_trig(); wait_done(200);
    chk(done == 1, "R8 done set", done, 1);
    chk(ptc_seen == 3, "R6 post buckets", ptc_seen, 3);
    a = wr_addr;
    pulse_trig(); tick(20);
    chk(done == 1 && wr_addr == a, "R7 trigger after done", wr_addr, a);

    // Four samples per bucket, trigger twice (second ignored).
    do_arm(3, 2);
    chk(done == 0, "R2 arm clears done", done, 0);
    tick(5); pulse_trig(); tick(3); pulse_trig(); wait_done(500);
    chk(ptc_seen == 2, "R7 retrigger ignored", ptc_seen, 2);

    // Longest bucket.
    do_arm(255, 1);
    tick(1000); pulse_trig(); wait_done(3000);
    chk(done == 1 && ptc_seen == 1, "R8 long bucket done", ptc_seen, 1);

    // post count zero acts as one.
    do_arm(2, 0);
    tick(2); pulse_trig(); wait_done(200);
    chk(done == 1 && ptc_seen == 1, "R8 zero post count", ptc_seen, 1);

    // Trigger in the arm cycle is ignored.
    do_arm(0, 1, 1);
    tick(40);
    chk(done == 0 && ptc_seen == 0, "R7 trigger with arm", ptc_seen, 0);
    pulse_trig(); wait_done(50);
    chk(done == 1, "R7 later trigger accepted", done, 1);

    // Address wrap.
    do_arm(0, 1);
    for (int i = 0; i < 70000 && !(wr_addr == 15'd32767 && addr_en); i++) tick();
    chk(wr_addr == 15'd32767 && addr_en, "R5 reached top", wr_addr, 32767);
    tick();
    chk(wr_addr == 0, "R5 wrap to zero", wr_addr, 0);
    pulse_trig(); wait_done(50);
    chk(done == 1, "R8 done after wrap", done, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule